// File: doc/BRIEF.md
# DMA Descriptor Fetch Controller

This block keeps a DMA engine fed with work. Software places a table in host memory: a block of one-dword status entries at the table base, followed by 32-byte descriptors. It then programs the base address and moves a last-index register forward. For each index from the next unprocessed one up to and including the programmed last index, the controller reads the descriptor with an 8-dword burst on a memory read master. It decodes the source address, destination address, length and identifier, and offers them to a data mover on a valid/ready output.

Only one descriptor is with the mover at any time. The controller waits for the mover to return a completion carrying the descriptor identifier. Depending on a reporting mode, it then writes a done word into that descriptor's status entry through a memory write master and moves on. One instance serves one transfer direction. Read-direction and write-direction transfers each use their own instance and their own table of up to 128 entries.

Top module: `desc_fetch_ctrl`

## Requirements
- R1: Register map on the 32-bit port: 0x08 holds the base address bits [31:0], 0x0C holds bits [63:32], 0x10 holds the last index (bits [6:0]), and 0x14 holds the reporting mode (bit 0). Each register reads back its written value on `reg_rdata` in the same cycle the address is presented; other bits read as zero.
- R2: Descriptor n is fetched with one read request at address base + 512 + 32*n, with `mrd_burst` = 8. The request and its address are held unchanged while `mrd_wait` is high.
- R3: A write to the last-index register causes descriptors to be processed in ascending order. Processing starts at the next unprocessed index and ends after the written index. The index wraps from 127 to 0. Writing 63 and then 127 processes 0–63 and then 64–127.
- R4: If the last-index register is written with the index most recently processed, no fetch starts.
- R5: The descriptor output carries the fields of the fetched dwords: source = {dword1, dword0}, destination = {dword3, dword2}, length = dword4[17:0], identifier = dword4[24:18]. `dsc_valid` rises only after all 8 read beats have arrived, and it stays high with stable fields until `dsc_ready`.
- R6: At most one descriptor is outstanding. After the handshake, the controller neither fetches nor offers again until `cpl_valid` arrives with `cpl_id` equal to {1'b0, identifier}. A completion with any other value is ignored.
- R7: With mode bit 0 set, every descriptor n gets a status write at base + 4*n. The data has bit 31 set, the identifier in bits [6:0], and all other bits zero. The write is issued after the matching completion.
- R8: With mode bit 0 clear, only the descriptor whose index equals the last index gets a status write.
- R9: The status write request, its address and its data are held while `mwr_wait` is high. The read and write masters never request in the same cycle.
- R10: After reset all registers read zero, and `mrd_req`, `mwr_req` and `dsc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mrd_req | output | 1 | Descriptor read request |
| mrd_addr | output | 64 | Descriptor read byte address |
| mrd_burst | output | 4 | Burst length in dwords (8) |
| mrd_wait | input | 1 | Read request not accepted this cycle |
| mrd_rvalid | input | 1 | Read data beat valid |
| mrd_rdata | input | 32 | Read data beat |
| dsc_valid | output | 1 | Descriptor offered to mover |
| dsc_ready | input | 1 | Mover accepts descriptor |
| dsc_src | output | 64 | Source address |
| dsc_dst | output | 64 | Destination address |
| dsc_len | output | 18 | Length in dwords |
| dsc_id | output | 7 | Descriptor identifier |
| cpl_valid | input | 1 | Mover completion strobe |
| cpl_id | input | 8 | Identifier of completed descriptor |
| mwr_req | output | 1 | Status write request |
| mwr_addr | output | 64 | Status write byte address |
| mwr_data | output | 32 | Status done word |
| mwr_wait | input | 1 | Write request not accepted this cycle |

## Verification
A wrong next-index or armed flag shows up at the next read request as a wrong `mrd_addr`, or as a request that never comes. The bench sees it within one descriptor period of about 20 cycles. A corrupted beat buffer or field decode appears on the descriptor fields at the very next handshake. A wrong mode or last-index comparison shows up as a missing, extra or misaddressed status write once the completion is accepted. A false completion match shows up within the 12-cycle window, while the bench withholds the true identifier, as a premature status write or fetch.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

  localparam int unsigned USED_DW = 5;
  localparam int unsigned LEN_W   = 18;
  localparam int unsigned ID_W    = 7;
  localparam int unsigned SLOT_B  = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_BEAT, ST_OFFER, ST_CPL, ST_DONE
  } seq_st_e;

  typedef struct packed {
    logic [63:0]      src;
    logic [63:0]      dst;
    logic [LEN_W-1:0] len;
    logic [ID_W-1:0]  id;
  } desc_t;

  // descriptors start after the status block of one dword per entry
  function automatic logic [63:0] slot_addr(input logic [63:0] base,
                                            input int unsigned depth,
                                            input int unsigned idx);
    return base + 64'(depth) * 64'd4 + 64'(idx) * 64'(SLOT_B);
  endfunction

  function automatic logic [63:0] flag_addr(input logic [63:0] base,
                                            input int unsigned idx);
    return base + 64'(idx) * 64'd4;
  endfunction

  function automatic desc_t unpack_desc(input logic [31:0] w0, input logic [31:0] w1,
                                        input logic [31:0] w2, input logic [31:0] w3,
                                        input logic [31:0] w4);
    desc_t d;
    d.src = {w1, w0};
    d.dst = {w3, w2};
    d.len = w4[LEN_W-1:0];
    d.id  = w4[LEN_W+ID_W-1:LEN_W];
    return d;
  endfunction

  function automatic logic [31:0] done_word(input logic [ID_W-1:0] id);
    return {1'b1, 24'd0, id};
  endfunction

endpackage

// File: rtl/dfc_regs.sv
module dfc_regs #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [63:0]      base,
  output logic [IDX_W-1:0] last_ptr,
  output logic             mode_all,
  output logic             last_wr,
  output logic [IDX_W-1:0] last_wval
);
  localparam logic [7:0] OFS_BASE_LO = 8'h08;
  localparam logic [7:0] OFS_BASE_HI = 8'h0C;
  localparam logic [7:0] OFS_LAST    = 8'h10;
  localparam logic [7:0] OFS_MODE    = 8'h14;

  assign last_wr   = wr_en && (addr == OFS_LAST);
  assign last_wval = wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base     <= '0;
      last_ptr <= '0;
      mode_all <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        OFS_BASE_LO: base[31:0]  <= wdata;
        OFS_BASE_HI: base[63:32] <= wdata;
        OFS_LAST:    last_ptr    <= last_wval;
        OFS_MODE:    mode_all    <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_BASE_LO: rdata = base[31:0];
      OFS_BASE_HI: rdata = base[63:32];
      OFS_LAST:    rdata = 32'(last_ptr);
      OFS_MODE:    rdata = {31'd0, mode_all};
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/dfc_ptr.sv
module dfc_ptr #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             last_wr,
  input  logic [IDX_W-1:0] last_wval,
  input  logic [IDX_W-1:0] last_ptr,
  input  logic             retire,
  output logic [IDX_W-1:0] fetch_idx,
  output logic             armed,
  output logic             at_last
);
  logic [IDX_W-1:0] idx_n;
  logic             any_q, any_n, arm_n;

  assign at_last = (fetch_idx == last_ptr);

  always_comb begin
    idx_n = retire ? fetch_idx + IDX_W'(1) : fetch_idx;
    any_n = any_q | retire;
    arm_n = armed;
    if (retire && at_last) arm_n = 1'b0;
    // a write naming the index already processed leaves the controller idle
    if (last_wr) arm_n = !(any_n && (last_wval == idx_n - IDX_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_idx <= '0;
      any_q     <= 1'b0;
      armed     <= 1'b0;
    end else begin
      fetch_idx <= idx_n;
      any_q     <= any_n;
      armed     <= arm_n;
    end
  end
endmodule

// File: rtl/dfc_seq.sv
module dfc_seq
  import dfc_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int BURST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic [IDX_W-1:0] fetch_idx,
  input  logic             at_last,
  input  logic             mode_all,
  input  logic [63:0]      base,
  output logic             mrd_req,
  output logic [63:0]      mrd_addr,
  input  logic             mrd_wait,
  input  logic             mrd_rvalid,
  input  logic [31:0]      mrd_rdata,
  output logic             dsc_valid,
  input  logic             dsc_ready,
  output desc_t            desc,
  input  logic             cpl_valid,
  input  logic [7:0]       cpl_id,
  output logic             mwr_req,
  output logic [63:0]      mwr_addr,
  output logic [31:0]      mwr_data,
  input  logic             mwr_wait,
  output logic             retire,
  output logic             await_cpl,
  output logic             cpl_hit
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = $clog2(BURST);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             last_beat, want_flag;
  logic [31:0]      beats [USED_DW];

  // only the dwords that carry fields are kept; the pad beats are dropped
  for (genvar g = 0; g < USED_DW; g++) begin : g_beat
    logic [31:0] w_q;
    always_ff @(posedge clk) begin
      if (st_q == ST_BEAT && mrd_rvalid && cnt_q == CNT_W'(g)) w_q <= mrd_rdata;
    end
    assign beats[g] = w_q;
  end

  assign desc      = unpack_desc(beats[0], beats[1], beats[2], beats[3], beats[4]);
  assign last_beat = mrd_rvalid && (cnt_q == CNT_W'(BURST - 1));
  assign want_flag = mode_all || at_last;

  assign mrd_req   = (st_q == ST_REQ);
  assign mrd_addr  = slot_addr(base, DEPTH, 32'(fetch_idx));
  assign dsc_valid = (st_q == ST_OFFER);
  assign await_cpl = (st_q == ST_CPL);
  assign cpl_hit   = await_cpl && cpl_valid && (cpl_id == 8'(desc.id));
  assign mwr_req   = (st_q == ST_DONE);
  assign mwr_addr  = flag_addr(base, 32'(fetch_idx));
  assign mwr_data  = done_word(desc.id);
  assign retire    = (cpl_hit && !want_flag) || (mwr_req && !mwr_wait);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (armed)      st_d = ST_REQ;
      ST_REQ:   if (!mrd_wait)  st_d = ST_BEAT;
      ST_BEAT:  if (last_beat)  st_d = ST_OFFER;
      ST_OFFER: if (dsc_ready)  st_d = ST_CPL;
      ST_CPL:   if (cpl_hit)    st_d = want_flag ? ST_DONE : ST_IDLE;
      ST_DONE:  if (!mwr_wait)  st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_REQ)                    cnt_q <= '0;
      else if (st_q == ST_BEAT && mrd_rvalid) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/desc_fetch_ctrl.sv
module desc_fetch_ctrl
  import dfc_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int BURST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mrd_req,
  output logic [63:0]      mrd_addr,
  output logic [3:0]       mrd_burst,
  input  logic             mrd_wait,
  input  logic             mrd_rvalid,
  input  logic [31:0]      mrd_rdata,
  output logic             dsc_valid,
  input  logic             dsc_ready,
  output logic [63:0]      dsc_src,
  output logic [63:0]      dsc_dst,
  output logic [17:0]      dsc_len,
  output logic [6:0]       dsc_id,
  input  logic             cpl_valid,
  input  logic [7:0]       cpl_id,
  output logic             mwr_req,
  output logic [63:0]      mwr_addr,
  output logic [31:0]      mwr_data,
  input  logic             mwr_wait
);
  logic [63:0]      base;
  logic [IDX_W-1:0] last_ptr, last_wval, fetch_idx;
  logic             mode_all, last_wr, armed, at_last;
  logic             retire, await_cpl, cpl_hit;
  desc_t            desc;

  assign mrd_burst = 4'(BURST);
  assign dsc_src   = desc.src;
  assign dsc_dst   = desc.dst;
  assign dsc_len   = desc.len;
  assign dsc_id    = desc.id;

  dfc_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .base(base), .last_ptr(last_ptr), .mode_all(mode_all),
    .last_wr(last_wr), .last_wval(last_wval)
  );

  dfc_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .last_wr(last_wr), .last_wval(last_wval),
    .last_ptr(last_ptr), .retire(retire), .fetch_idx(fetch_idx),
    .armed(armed), .at_last(at_last)
  );

  dfc_seq #(.IDX_W(IDX_W), .BURST(BURST)) u_seq (
    .clk(clk), .rst_n(rst_n), .armed(armed), .fetch_idx(fetch_idx), .at_last(at_last),
    .mode_all(mode_all), .base(base), .mrd_req(mrd_req), .mrd_addr(mrd_addr),
    .mrd_wait(mrd_wait), .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
    .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .desc(desc),
    .cpl_valid(cpl_valid), .cpl_id(cpl_id), .mwr_req(mwr_req), .mwr_addr(mwr_addr),
    .mwr_data(mwr_data), .mwr_wait(mwr_wait), .retire(retire),
    .await_cpl(await_cpl), .cpl_hit(cpl_hit)
  );
endmodule

// File: rtl/dfc_chk.sv
module dfc_chk #(
  parameter int BURST = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mrd_req,
  input logic        mrd_wait,
  input logic [63:0] mrd_addr,
  input logic        mrd_rvalid,
  input logic        dsc_valid,
  input logic        dsc_ready,
  input logic [63:0] dsc_src,
  input logic [6:0]  dsc_id,
  input logic        mwr_req,
  input logic        mwr_wait,
  input logic [63:0] mwr_addr,
  input logic [31:0] mwr_data,
  input logic        await_cpl
);
  int unsigned seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    seen_q <= 0;
    else if (mrd_req && !mrd_wait) seen_q <= 0;
    else if (mrd_rvalid)           seen_q <= seen_q + 1;
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req && mrd_wait |=> mrd_req && $stable(mrd_addr));

  // R5
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_src) && $stable(dsc_id));

  // R5
  full_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsc_valid) |-> seen_q == BURST);

  // R6
  single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    await_cpl |-> !dsc_valid && !mrd_req);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mwr_req && mwr_wait |=> mwr_req && $stable(mwr_addr) && $stable(mwr_data));

  // R9
  excl_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mrd_req && mwr_req));

  // R7
  flag_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mwr_req |-> mwr_data[31] && mwr_data[30:7] == 24'd0);
endmodule

bind desc_fetch_ctrl dfc_chk #(.BURST(BURST)) u_chk (
  .clk(clk), .rst_n(rst_n), .mrd_req(mrd_req), .mrd_wait(mrd_wait), .mrd_addr(mrd_addr),
  .mrd_rvalid(mrd_rvalid), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
  .dsc_src(dsc_src), .dsc_id(dsc_id), .mwr_req(mwr_req), .mwr_wait(mwr_wait),
  .mwr_addr(mwr_addr), .mwr_data(mwr_data), .await_cpl(await_cpl)
);

// File: tb/desc_fetch_ctrl_test.sv
`timescale 1ns/1ps
module desc_fetch_ctrl_test;
  localparam logic [63:0] BASE = 64'h0000_0012_3400_0000;
  // {mode, last, expected descriptors, expected status writes}
  localparam logic [31:0] VEC [5] = '{
    32'h01_3F_40_40, 32'h00_7F_40_01, 32'h01_7F_00_00, 32'h01_02_03_03, 32'h00_05_03_01
  };

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [7:0] reg_addr = 0; logic [31:0] reg_wdata = 0; logic [31:0] reg_rdata;
  logic mrd_req; logic [63:0] mrd_addr; logic [3:0] mrd_burst;
  logic mrd_wait = 1, mrd_rvalid = 0; logic [31:0] mrd_rdata = 0;
  logic dsc_valid, dsc_ready = 0; logic [63:0] dsc_src, dsc_dst; logic [17:0] dsc_len; logic [6:0] dsc_id;
  logic cpl_valid = 0; logic [7:0] cpl_id = 0;
  logic mwr_req; logic [63:0] mwr_addr; logic [31:0] mwr_data; logic mwr_wait = 1;

  int total = 0, bad = 0;
  int b_idx = 0, taken = 0, cur_mode = 0, cur_last = 0, n_desc = 0, n_stat = 0;
  bit bogus = 0, finished = 0;

  always #2 clk = ~clk;

  desc_fetch_ctrl uut (.*);

  function automatic logic [6:0] id_of(input int n); return 7'((n * 37 + 11) % 128); endfunction
  function automatic logic [17:0] len_of(input int n); return 18'(n * 3 + 1); endfunction
  function automatic logic [31:0] mem_word(input int n, input int k);
    case (k)
      0: return 32'h1000_0000 + 32'(n * 16);
      1: return 32'h0000_00A0 + 32'(n);
      2: return 32'h2000_0000 + 32'(n * 64);
      3: return 32'h0000_00B0 + 32'(n);
      4: return {7'd0, id_of(n), len_of(n)};
      default: return 32'hDEAD_0000 + 32'(k);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == e, req, 64'(reg_rdata), 64'(e));
    reg_addr = 0;
  endtask

  task automatic run(input int mode, input int last, input int e_d, input int e_s, input string req);
    n_desc = 0; n_stat = 0; cur_mode = mode; cur_last = last;
    wr(8'h14, 32'(mode));
    wr(8'h10, 32'(last));
    for (int t = 0; t < 30000 && !(n_desc >= e_d && n_stat >= e_s); t++) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(n_desc == e_d, req, 64'(n_desc), 64'(e_d));
    chk(n_stat == e_s, cur_mode ? "R7" : "R8", 64'(n_stat), 64'(e_s));
  endtask

  // memory read responder: two wait cycles, then eight beats
  initial forever begin
    @(negedge clk);
    if (mrd_req) begin
      repeat (2) @(negedge clk);
      chk(mrd_addr == BASE + 64'd512 + 64'(b_idx * 32), "R2 fetch address", mrd_addr,
          BASE + 64'd512 + 64'(b_idx * 32));
      chk(mrd_burst == 4'd8, "R2 burst", 64'(mrd_burst), 64'd8);
      mrd_wait = 0; @(negedge clk); mrd_wait = 1;
      for (int k = 0; k < 8; k++) begin
        mrd_rvalid = 1; mrd_rdata = mem_word(b_idx, k); @(negedge clk);
      end
      mrd_rvalid = 0;
    end
  end

  // mover model
  initial forever begin
    @(negedge clk);
    if (dsc_valid) begin
      @(negedge clk);
      // R3 order and wrap, R5 field decode
      chk(dsc_src == {32'h0000_00A0 + 32'(b_idx), 32'h1000_0000 + 32'(b_idx * 16)}, "R5 src",
          dsc_src, {32'h0000_00A0 + 32'(b_idx), 32'h1000_0000 + 32'(b_idx * 16)});
      chk(dsc_dst == {32'h0000_00B0 + 32'(b_idx), 32'h2000_0000 + 32'(b_idx * 64)}, "R5 dst",
          dsc_dst, {32'h0000_00B0 + 32'(b_idx), 32'h2000_0000 + 32'(b_idx * 64)});
      chk(dsc_len == len_of(b_idx) && dsc_id == id_of(b_idx), "R3 R5 len/id",
          {39'd0, dsc_id, dsc_len}, {39'd0, id_of(b_idx), len_of(b_idx)});
      dsc_ready = 1; @(negedge clk); dsc_ready = 0;
      taken = b_idx; b_idx = (b_idx + 1) % 128; n_desc++;
      repeat (3) @(negedge clk);
      if (bogus) begin
        cpl_valid = 1; cpl_id = {1'b0, id_of(taken) ^ 7'h01}; @(negedge clk);
        cpl_id = {1'b1, id_of(taken)}; @(negedge clk);
        cpl_valid = 0;
        repeat (12) @(negedge clk);
        chk(n_stat == 0 && !mrd_req && !dsc_valid, "R6 mismatched completion ignored",
            {62'd0, mrd_req, dsc_valid} + 64'(n_stat * 4), 64'd0);
        bogus = 0;
      end
      cpl_valid = 1; cpl_id = {1'b0, id_of(taken)}; @(negedge clk); cpl_valid = 0;
    end
  end

  // status write responder
  initial forever begin
    @(negedge clk);
    if (mwr_req) begin
      @(negedge clk);
      chk(mwr_addr == BASE + 64'(taken * 4), "R7 status address", mwr_addr, BASE + 64'(taken * 4));
      chk(mwr_data == {1'b1, 24'd0, id_of(taken)}, "R7 done word", 64'(mwr_data),
          64'({1'b1, 24'd0, id_of(taken)}));
      if (!cur_mode) chk(taken == cur_last, "R8 only last index", 64'(taken), 64'(cur_last));
      mwr_wait = 0; @(negedge clk); mwr_wait = 1;
      n_stat++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1; total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk(!mrd_req && !mwr_req && !dsc_valid, "R10 idle outputs",
        {61'd0, mrd_req, mwr_req, dsc_valid}, 64'd0);
    rd_chk(8'h08, 32'd0, "R10 base lo");
    rd_chk(8'h0C, 32'd0, "R10 base hi");
    rd_chk(8'h10, 32'd0, "R10 last");
    rd_chk(8'h14, 32'd0, "R10 mode");
    wr(8'h08, BASE[31:0]);
    wr(8'h0C, BASE[63:32]);
    rd_chk(8'h08, BASE[31:0], "R1 base lo");
    rd_chk(8'h0C, BASE[63:32], "R1 base hi");
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk(8'h14, 32'd1, "R1 mode");
    wr(8'h14, 32'd0);
    repeat (20) @(negedge clk);
    chk(!mrd_req, "R4 no fetch without last write", 64'(mrd_req), 64'd0);

    foreach (VEC[i]) begin
      run(int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]),
          VEC[i][15:8] == 8'd0 ? "R4 already reached" : "R3 descriptor count");
    end
    rd_chk(8'h10, 32'd5, "R1 last readback");

    // R6 directed: wrong identifiers while one descriptor is outstanding
    bogus = 1;
    run(1, 6, 1, 1, "R6 one descriptor");
    // R4 directed: same index again
    run(0, 6, 0, 0, "R4 rewrite same index");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule